// File: doc/BRIEF.md
# Call, Return and Interrupt Sequencer

This block moves program flow between a running program, its subroutines and its interrupt handlers. It keeps the stack pointer. The return state lives in a stack in ordinary memory, reached through a single-port memory interface. A plain call saves only the return PC. Entering a handler, whether from a hardware request or from a supervisor-call command, saves the PC and then the status word. The block then hands back a vector and a new status word. Returning from a handler pops both values in the reverse order.

The PC and status registers stay outside the block. The block samples their current values when it accepts a sequence. When the sequence ends, it returns new values with one-cycle load strobes. A hardware request is looked at only in an idle cycle in which the end-of-instruction strobe is high. This means that a handler is always entered between two instructions. Each stack access takes one memory cycle. The read data is taken from the memory in the same cycle as the address. While a sequence is running, `busy` is high and new commands are not accepted.

Top module: `flow_sequencer`

## Requirements
- R1: While and after reset, `sp` equals `SP_INIT`, and `busy`, `mem_req`, `pc_load` and `sw_load` are all 0.
- R2: Operation code 00 (call) is accepted in an idle cycle. In the next cycle there is one memory write of the `pc_in` value sampled at acceptance, at address `sp`-1. In the cycle after that, `sp` has moved down by one, and `pc_load` is high with `pc_next` equal to the target sampled at acceptance.
- R3: Operation code 01 (return) is followed in the next cycle by one memory read at address `sp`. In the cycle after that, `sp` has moved up by one, and `pc_load` is high with `pc_next` equal to the word that was read.
- R4: A hardware interrupt is taken only when the block is idle, `end_of_instr` is high, `irq_req` is high and the enable bit (bit `IE_BIT`, 0 by default) of `sw_in` is set. In any other case there is no memory access and `busy` stays low.
- R5: A taken hardware interrupt makes exactly two writes on consecutive cycles: first the PC at `sp`-1, then the zero-extended status word at `sp`-2. The cycle after the second write, `sp` has moved down by two, `pc_next` equals `irq_vector`, and `sw_next` equals `irq_sw` with the enable bit cleared. Both load strobes are high in that cycle.
- R6: Operation code 10 (return from interrupt) reads the status word at `sp`, then the PC at `sp`+1, on consecutive cycles. The cycle after the second read, `sp` has moved up by two, and both load strobes are high with the two restored values.
- R7: Operation code 11 (supervisor call) does not depend on the enable bit. It pushes the same two words as R5. It then loads `pc_next` with `SVC_VECTOR`, and `sw_next` with the current status word with the supervisor bit (bit `SUP_BIT`, 1 by default) set and the enable bit cleared.
- R8: `busy` is high exactly during the memory-access cycles of a sequence, and load strobes appear only when `busy` is low. A command presented while `busy` is high has no effect on the running sequence, and no further memory cycle follows it.
- R9: If a hardware interrupt qualifies in the same cycle as a command, the interrupt sequence runs and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 call, 01 return, 10 return from interrupt, 11 supervisor call |
| cmd_target | input | ADDR_W | Call destination address |
| end_of_instr | input | 1 | High in the last cycle of an instruction |
| irq_req | input | 1 | External interrupt request |
| irq_vector | input | ADDR_W | Handler start address for the request |
| irq_sw | input | SW_W | Status word for the handler |
| pc_in | input | ADDR_W | Current PC (return address) |
| sw_in | input | SW_W | Current status word |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Stack word address |
| mem_wdata | output | ADDR_W | Write data |
| mem_rdata | input | ADDR_W | Read data, valid in the access cycle |
| busy | output | 1 | Sequence in progress |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | ADDR_W | New PC |
| sw_load | output | 1 | Load `sw_next` into the status register |
| sw_next | output | SW_W | New status word |
| sp | output | ADDR_W | Stack pointer |

## Verification
Counting from the edge at which a command or a qualifying request is sampled, the first memory access shows on the ports one cycle later. A call or a return completes with its PC load two cycles later. The two-access sequences complete with both loads three cycles later. The bench drives stimulus and samples outputs on falling edges. Each task checks memory address, direction and data at every access cycle and the loads in the final cycle, and compares them with a stack image that the bench keeps itself. Checks that a stimulus is ignored look at `busy` and `mem_req` in the cycle right after that stimulus.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

    typedef enum logic [1:0] {
        OP_CALL = 2'b00,
        OP_RET  = 2'b01,
        OP_RETI = 2'b10,
        OP_SWI  = 2'b11
    } seq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALL_PUSH,
        ST_INT_PUSH_PC,
        ST_INT_PUSH_SW,
        ST_RET_POP,
        ST_RETI_POP_SW,
        ST_RETI_POP_PC
    } seq_state_e;

endpackage

// File: rtl/fseq_launch.sv
module fseq_launch
    import flow_seq_pkg::*;
(
    input  logic       idle_i,
    input  logic       cmd_valid_i,
    input  seq_op_e    cmd_op_i,
    input  logic       eoi_i,
    input  logic       irq_req_i,
    input  logic       irq_en_i,
    output logic       start_o,
    output seq_state_e first_o,
    output logic       hw_irq_o
);

    // A qualifying hardware request outranks any command in the same cycle.
    always_comb begin
        start_o  = 1'b0;
        first_o  = ST_IDLE;
        hw_irq_o = 1'b0;
        if (idle_i && eoi_i && irq_req_i && irq_en_i) begin
            start_o  = 1'b1;
            first_o  = ST_INT_PUSH_PC;
            hw_irq_o = 1'b1;
        end else if (idle_i && cmd_valid_i) begin
            start_o = 1'b1;
            unique case (cmd_op_i)
                OP_CALL: first_o = ST_CALL_PUSH;
                OP_RET:  first_o = ST_RET_POP;
                OP_RETI: first_o = ST_RETI_POP_SW;
                OP_SWI:  first_o = ST_INT_PUSH_PC;
                default: first_o = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fseq_mem_port.sv
module fseq_mem_port
    import flow_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SW_W   = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  seq_state_e        state_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] ret_pc_i,
    input  logic [SW_W-1:0]   save_sw_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [ADDR_W-1:0] mem_wdata_o
);

    logic [ADDR_W-1:0] push_addr;
    assign push_addr = sp_i - 1'b1;

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = sp_i;
        mem_wdata_o = ret_pc_i;
        unique case (state_i)
            ST_CALL_PUSH, ST_INT_PUSH_PC: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = push_addr;
            end
            ST_INT_PUSH_SW: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = push_addr;
                mem_wdata_o = ADDR_W'(save_sw_i);
            end
            ST_RET_POP, ST_RETI_POP_SW, ST_RETI_POP_PC: begin
                mem_req_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R2 R5: after a push the stack pointer names the word just written.
    assert_push_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o) |=> (sp_i == $past(mem_addr_o)));

    // R3 R6: after a pop the stack pointer sits one above the word read.
    assert_pop_moves_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_we_o) |=> (sp_i == $past(mem_addr_o) + 1'b1));

endmodule

// File: rtl/fseq_core.sv
module fseq_core
    import flow_seq_pkg::*;
#(
    parameter int                 ADDR_W     = 16,
    parameter int                 SW_W       = 8,
    parameter int                 IE_BIT     = 0,
    parameter int                 SUP_BIT    = 1,
    parameter logic [ADDR_W-1:0]  SP_INIT    = '0,
    parameter logic [ADDR_W-1:0]  SVC_VECTOR = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  seq_state_e        first_i,
    input  logic              hw_irq_i,
    input  logic [ADDR_W-1:0] cmd_target_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [SW_W-1:0]   sw_i,
    input  logic [ADDR_W-1:0] irq_vector_i,
    input  logic [SW_W-1:0]   irq_sw_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    input  logic              eoi_i,
    input  logic              irq_req_i,
    output seq_state_e        state_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] ret_pc_o,
    output logic [SW_W-1:0]   save_sw_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_next_o,
    output logic              sw_load_o,
    output logic [SW_W-1:0]   sw_next_o
);

    localparam logic [SW_W-1:0] IE_MASK  = SW_W'(1) << IE_BIT;
    localparam logic [SW_W-1:0] SUP_MASK = SW_W'(1) << SUP_BIT;

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] ret_pc;
        logic [SW_W-1:0]   save_sw;
        logic [ADDR_W-1:0] tgt_pc;
        logic [SW_W-1:0]   new_sw;
        logic              hw;
        logic              pc_load;
        logic [ADDR_W-1:0] pc_next;
        logic              sw_load;
        logic [SW_W-1:0]   sw_next;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        r_d.pc_load = 1'b0;
        r_d.sw_load = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state   = first_i;
                    r_d.ret_pc  = pc_i;
                    r_d.save_sw = sw_i;
                    r_d.hw      = hw_irq_i;
                    r_d.tgt_pc  = cmd_target_i;
                    if (first_i == ST_INT_PUSH_PC) begin
                        if (hw_irq_i) begin
                            r_d.tgt_pc = irq_vector_i;
                            r_d.new_sw = irq_sw_i & ~IE_MASK;
                        end else begin
                            r_d.tgt_pc = SVC_VECTOR;
                            r_d.new_sw = (sw_i | SUP_MASK) & ~IE_MASK;
                        end
                    end
                end
            end
            ST_CALL_PUSH: begin
                r_d.sp      = r_q.sp - 1'b1;
                r_d.state   = ST_IDLE;
                r_d.pc_load = 1'b1;
                r_d.pc_next = r_q.tgt_pc;
            end
            ST_INT_PUSH_PC: begin
                r_d.sp    = r_q.sp - 1'b1;
                r_d.state = ST_INT_PUSH_SW;
            end
            ST_INT_PUSH_SW: begin
                r_d.sp      = r_q.sp - 1'b1;
                r_d.state   = ST_IDLE;
                r_d.pc_load = 1'b1;
                r_d.pc_next = r_q.tgt_pc;
                r_d.sw_load = 1'b1;
                r_d.sw_next = r_q.new_sw;
            end
            ST_RET_POP: begin
                r_d.sp      = r_q.sp + 1'b1;
                r_d.state   = ST_IDLE;
                r_d.pc_load = 1'b1;
                r_d.pc_next = mem_rdata_i;
            end
            ST_RETI_POP_SW: begin
                r_d.sp     = r_q.sp + 1'b1;
                r_d.new_sw = mem_rdata_i[SW_W-1:0];
                r_d.state  = ST_RETI_POP_PC;
            end
            ST_RETI_POP_PC: begin
                r_d.sp      = r_q.sp + 1'b1;
                r_d.state   = ST_IDLE;
                r_d.pc_load = 1'b1;
                r_d.pc_next = mem_rdata_i;
                r_d.sw_load = 1'b1;
                r_d.sw_next = r_q.new_sw;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.sp    <= SP_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o   = r_q.state;
    assign sp_o      = r_q.sp;
    assign ret_pc_o  = r_q.ret_pc;
    assign save_sw_o = r_q.save_sw;
    assign pc_load_o = r_q.pc_load;
    assign pc_next_o = r_q.pc_next;
    assign sw_load_o = r_q.sw_load;
    assign sw_next_o = r_q.sw_next;

    // R4: a hardware entry began in a cycle that had a qualifying boundary request.
    assert_entry_at_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_INT_PUSH_PC && r_q.hw && $past(r_q.state) == ST_IDLE)
        |-> $past(eoi_i && irq_req_i && sw_i[IE_BIT]));

    // R5 R7: the status word handed to a handler never has the enable bit set.
    assert_entry_masks_ie_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.sw_load && $past(r_q.state) == ST_INT_PUSH_SW) |-> !r_q.sw_next[IE_BIT]);

    // R6: the PC pop of a handler return always follows its status pop.
    assert_reti_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RETI_POP_PC) |-> $past(r_q.state) == ST_RETI_POP_SW);

    // R8: loads are only presented once the sequence has released busy.
    assert_load_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.pc_load || r_q.sw_load) |-> r_q.state == ST_IDLE);

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
    import flow_seq_pkg::*;
#(
    parameter int                 ADDR_W     = 16,
    parameter int                 SW_W       = 8,
    parameter int                 IE_BIT     = 0,
    parameter int                 SUP_BIT    = 1,
    parameter logic [ADDR_W-1:0]  SP_INIT    = '0,
    parameter logic [ADDR_W-1:0]  SVC_VECTOR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_target,
    input  logic              end_of_instr,
    input  logic              irq_req,
    input  logic [ADDR_W-1:0] irq_vector,
    input  logic [SW_W-1:0]   irq_sw,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SW_W-1:0]   sw_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              busy,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_next,
    output logic              sw_load,
    output logic [SW_W-1:0]   sw_next,
    output logic [ADDR_W-1:0] sp
);

    seq_state_e        state;
    seq_state_e        first_state;
    logic              start;
    logic              hw_irq;
    logic [ADDR_W-1:0] ret_pc;
    logic [SW_W-1:0]   save_sw;

    assign busy = (state != ST_IDLE);

    fseq_launch u_launch (
        .idle_i      (state == ST_IDLE),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (seq_op_e'(cmd_op)),
        .eoi_i       (end_of_instr),
        .irq_req_i   (irq_req),
        .irq_en_i    (sw_in[IE_BIT]),
        .start_o     (start),
        .first_o     (first_state),
        .hw_irq_o    (hw_irq)
    );

    fseq_core #(
        .ADDR_W     (ADDR_W),
        .SW_W       (SW_W),
        .IE_BIT     (IE_BIT),
        .SUP_BIT    (SUP_BIT),
        .SP_INIT    (SP_INIT),
        .SVC_VECTOR (SVC_VECTOR)
    ) u_core (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .first_i      (first_state),
        .hw_irq_i     (hw_irq),
        .cmd_target_i (cmd_target),
        .pc_i         (pc_in),
        .sw_i         (sw_in),
        .irq_vector_i (irq_vector),
        .irq_sw_i     (irq_sw),
        .mem_rdata_i  (mem_rdata),
        .eoi_i        (end_of_instr),
        .irq_req_i    (irq_req),
        .state_o      (state),
        .sp_o         (sp),
        .ret_pc_o     (ret_pc),
        .save_sw_o    (save_sw),
        .pc_load_o    (pc_load),
        .pc_next_o    (pc_next),
        .sw_load_o    (sw_load),
        .sw_next_o    (sw_next)
    );

    fseq_mem_port #(
        .ADDR_W (ADDR_W),
        .SW_W   (SW_W)
    ) u_mem_port (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .state_i     (state),
        .sp_i        (sp),
        .ret_pc_i    (ret_pc),
        .save_sw_i   (save_sw),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata)
    );

    // R8: memory is touched only while busy is reported.
    assert_mem_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

// File: tb/flow_sequencer_bench.sv
module flow_sequencer_bench;

    localparam logic [7:0] SP0 = 8'h80;
    localparam logic [7:0] SVC = 8'hF0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_target = 8'h00;
    logic       end_of_instr = 1'b0;
    logic       irq_req = 1'b0;
    logic [7:0] irq_vector = 8'h00;
    logic [3:0] irq_sw = 4'h0;
    logic [7:0] cpu_pc = 8'h00;
    logic [3:0] cpu_sw = 4'h0;
    logic       mem_req, mem_we, busy, pc_load, sw_load;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, pc_next, sp;
    logic [3:0] sw_next;

    logic [7:0] mem [256];
    logic [7:0] stk [256];
    logic [7:0] sp_m;
    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem[mem_addr];

    flow_sequencer #(
        .ADDR_W(8), .SW_W(4), .IE_BIT(0), .SUP_BIT(1), .SP_INIT(SP0), .SVC_VECTOR(SVC)
    ) u_flow_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_target(cmd_target), .end_of_instr(end_of_instr), .irq_req(irq_req),
        .irq_vector(irq_vector), .irq_sw(irq_sw), .pc_in(cpu_pc), .sw_in(cpu_sw),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .pc_load(pc_load), .pc_next(pc_next),
        .sw_load(sw_load), .sw_next(sw_next), .sp(sp)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_call(input logic [7:0] tgt);
        logic [7:0] a;
        a = sp_m - 8'd1;
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_target = tgt;
        @(negedge clk); cmd_valid = 1'b0;
        check("R2 write strobe/busy", {busy, mem_req, mem_we}, 3'b111);
        check("R2 write addr", mem_addr, a);
        check("R2 write data", mem_wdata, cpu_pc);
        stk[a] = cpu_pc; sp_m = a;
        @(negedge clk);
        check("R2 loads/busy", {pc_load, sw_load, busy}, 3'b100);
        check("R2 target", pc_next, tgt);
        check("R2 sp", sp, sp_m);
        cpu_pc = pc_next;
    endtask

    task automatic do_ret();
        logic [7:0] e;
        e = stk[sp_m];
        cmd_valid = 1'b1; cmd_op = 2'b01;
        @(negedge clk); cmd_valid = 1'b0;
        check("R3 read strobe/busy", {busy, mem_req, mem_we}, 3'b110);
        check("R3 read addr", mem_addr, sp_m);
        @(negedge clk);
        sp_m = sp_m + 8'd1;
        check("R3 loads/busy", {pc_load, sw_load, busy}, 3'b100);
        check("R3 popped pc", pc_next, e);
        check("R3 sp", sp, sp_m);
        cpu_pc = pc_next;
    endtask

    task automatic do_int(input logic hw, input logic [7:0] vec, input logic [3:0] isw,
                          input logic with_cmd, input logic poke);
        logic [7:0] a1, a2, ev;
        logic [3:0] es;
        a1 = sp_m - 8'd1; a2 = sp_m - 8'd2;
        ev = hw ? vec : SVC;
        es = hw ? (isw & 4'b1110) : ((cpu_sw | 4'b0010) & 4'b1110);
        if (hw) begin
            end_of_instr = 1'b1; irq_req = 1'b1; irq_vector = vec; irq_sw = isw;
            if (with_cmd) begin cmd_valid = 1'b1; cmd_op = 2'b00; cmd_target = ~vec; end
        end else begin
            cmd_valid = 1'b1; cmd_op = 2'b11;
        end
        @(negedge clk);
        end_of_instr = 1'b0; irq_req = 1'b0; cmd_valid = 1'b0;
        if (poke) begin cmd_valid = 1'b1; cmd_op = 2'b01; end
        check(hw ? "R5 pc push strobe" : "R7 pc push strobe", {busy, mem_req, mem_we}, 3'b111);
        check(hw ? "R5 pc push addr" : "R7 pc push addr", mem_addr, a1);
        check(hw ? "R5 pc push data" : "R7 pc push data", mem_wdata, cpu_pc);
        @(negedge clk); cmd_valid = 1'b0;
        check(hw ? "R5 sw push strobe" : "R7 sw push strobe", {busy, mem_req, mem_we}, 3'b111);
        check(hw ? "R5 sw push addr" : "R7 sw push addr", mem_addr, a2);
        check(hw ? "R5 sw push data" : "R7 sw push data", mem_wdata, {4'h0, cpu_sw});
        stk[a1] = cpu_pc; stk[a2] = {4'h0, cpu_sw}; sp_m = a2;
        @(negedge clk);
        check(with_cmd ? "R9 loads/busy" : "R5 loads/busy", {pc_load, sw_load, busy}, 3'b110);
        check(with_cmd ? "R9 vector" : (hw ? "R5 vector" : "R7 vector"), pc_next, ev);
        check(hw ? "R5 new sw" : "R7 new sw", sw_next, es);
        check(hw ? "R5 sp" : "R7 sp", sp, sp_m);
        cpu_pc = pc_next; cpu_sw = sw_next;
        if (poke) begin
            @(negedge clk);
            check("R8 command while busy ignored", {busy, mem_req, pc_load}, 3'b000);
        end
    endtask

    task automatic do_reti();
        logic [7:0] a1, ep;
        logic [3:0] es;
        a1 = sp_m + 8'd1;
        es = stk[sp_m][3:0]; ep = stk[a1];
        cmd_valid = 1'b1; cmd_op = 2'b10;
        @(negedge clk); cmd_valid = 1'b0;
        check("R6 sw pop strobe", {busy, mem_req, mem_we}, 3'b110);
        check("R6 sw pop addr", mem_addr, sp_m);
        @(negedge clk);
        check("R6 pc pop strobe", {busy, mem_req, mem_we}, 3'b110);
        check("R6 pc pop addr", mem_addr, a1);
        @(negedge clk);
        sp_m = sp_m + 8'd2;
        check("R6 loads/busy", {pc_load, sw_load, busy}, 3'b110);
        check("R6 restored pc", pc_next, ep);
        check("R6 restored sw", sw_next, es);
        check("R6 sp", sp, sp_m);
        cpu_pc = pc_next; cpu_sw = sw_next;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails++; tests++;
            $display("FAIL watchdog R8 actual=%0d expected<20000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        sp_m = SP0;
        @(negedge clk);
        check("R1 in reset", {busy, mem_req, pc_load, sw_load}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset idle", {busy, mem_req, pc_load, sw_load}, 4'b0000);
        check("R1 sp init", sp, SP0);

        // R2/R3: nested calls then LIFO returns
        cpu_sw = 4'b0001;
        for (int i = 0; i < 24; i++) begin
            cpu_pc = 8'(i * 7 + 3);
            do_call(8'(i * 37 + 5));
        end
        for (int i = 0; i < 24; i++) do_ret();
        check("R3 sp back to start", sp, SP0);

        // R4: every non-qualifying combination of boundary, request and enable
        for (int c = 0; c < 7; c++) begin
            logic [2:0] b;
            b = 3'(c);
            cpu_sw = {3'b000, b[0]};
            irq_req = b[1]; end_of_instr = b[2]; irq_vector = 8'h33;
            @(negedge clk);
            irq_req = 1'b0; end_of_instr = 1'b0;
            check("R4 no entry without all conditions", {busy, mem_req}, 2'b00);
        end

        // R4: request at a boundary strobe while busy is not taken
        cpu_sw = 4'b0001; cpu_pc = 8'h21;
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_target = 8'h55;
        @(negedge clk); cmd_valid = 1'b0;
        stk[sp_m - 8'd1] = cpu_pc; sp_m = sp_m - 8'd1;
        end_of_instr = 1'b1; irq_req = 1'b1;
        @(negedge clk); end_of_instr = 1'b0; irq_req = 1'b0;
        check("R4 call finishes normally", {pc_load, busy}, 2'b10);
        cpu_pc = pc_next;
        @(negedge clk);
        check("R4 request during busy not taken", {busy, mem_req}, 2'b00);
        do_ret();

        // R5/R6: handler entry and return sweep, with a call inside each handler
        for (int k = 0; k < 16; k++) begin
            logic [3:0] kk;
            kk = 4'(k);
            cpu_pc = 8'(k * 11 + 1);
            cpu_sw = {kk[2:0], 1'b1};
            do_int(1'b1, 8'hA0 + 8'(k), ~kk, 1'b0, 1'b0);
            check("R5 handler runs with enable cleared", {28'h0, cpu_sw[0]}, 0);
            do_call(8'(k * 3));
            do_ret();
            do_reti();
            check("R6 enable restored", {28'h0, cpu_sw[0]}, 1);
        end

        // R7: supervisor call, with the enable bit both clear and set
        for (int k = 0; k < 8; k++) begin
            logic [3:0] kk;
            kk = 4'(k);
            cpu_pc = 8'(k * 29 + 2);
            cpu_sw = {kk[1:0], kk[2], kk[0]};
            do_int(1'b0, 8'h00, 4'h0, 1'b0, 1'b0);
            do_reti();
        end

        // R8: a command during the handler entry is ignored
        cpu_pc = 8'h44; cpu_sw = 4'b1001;
        do_int(1'b1, 8'hC4, 4'b0111, 1'b0, 1'b1);
        do_reti();

        // R9: same-cycle request and command: interrupt wins
        cpu_pc = 8'h5A; cpu_sw = 4'b0101;
        do_int(1'b1, 8'hD2, 4'b1011, 1'b1, 1'b0);
        do_reti();
        check("R9 stack balanced", sp, SP0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule